// File: doc/BRIEF.md
# NCO-Clocked Serial Port with Interrupt Register File

This block is a memory-mapped serial port for a simple 32-bit register bus. Software pushes bytes into a 32-entry transmit queue, and a shifter sends them as 8N1 frames on `ser_tx`: a low start bit, eight data bits least significant first, and a high stop bit. A receive shifter watches `ser_rx` and leaves each completed byte in a single holding register. A phase accumulator sets the serial bit rate. It adds a 16-bit increment every clock, and its carry is a 16x oversampling tick. Sixteen ticks make one bit period, so the bit rate is increment × f_clk / 2^20.

Four level interrupt lines come from a state, enable and test register triple. State bits are set by hardware events, cleared by writing ones, and can be forced by writing the test register. Each line is its state bit gated by its enable bit. Several control fields are only stored: parity, filtering, loopback, override, value and receive timeout. A write to them is kept and reads back, but it changes nothing.

The bus port takes a word index, which is the byte address divided by four. Writes take effect at the clock edge where `bus_sel` and `bus_we` are high. `bus_rdata` is combinational from the index. A read of the receive data word has its side effect at the edge where it is selected.

Top module: `uart_nco`

## Requirements
- R1: Interrupt state and enable bits are mapped as bit 0 tx watermark, bit 1 rx watermark, bit 2 tx empty and bit 3 rx overflow. Each of `irq_tx_wmark`, `irq_rx_wmark`, `irq_tx_empty` and `irq_rx_ovf` equals its state bit AND its enable bit, with no clock delay.
- R2: A write to the interrupt state word clears every state bit written as 1. A write to the interrupt test word sets the state bits written as 1. The test word always reads 0.
- R3: The word indices are 0 int state, 1 int enable, 2 int test, 3 control, 4 status, 5 receive data, 6 transmit data, 7 queue control, 8 queue status, 9 override, 10 value and 11 timeout control. The control, queue control, override, value and timeout words store the full 32-bit value written and read it back. Fields without a function have no effect.
- R4: Control bits 31:16 hold the increment N, and one bit lasts 16·65536/N clocks. A frame is 10 bit periods long: start bit 0, data bits LSB first, then stop bit 1. The line idles high.
- R5: The tx watermark state bit (bit 0) is set by a transmit-data write that takes the queue level to at least the threshold in queue control bits 12:8. It is cleared when transmission takes the level below that threshold, or to zero.
- R6: Queue status bits 5:0 give the transmit queue level. Writing queue control with bit 1 set makes the level 0. Status bit 0 (tx full) is 1 when the level is 32, and status bit 1 (tx empty) is 1 when the level is 0.
- R7: A transmit-data write while the queue holds 32 bytes is discarded, and the level stays 32.
- R8: Bytes leave the queue only while control bit 0 is 1. When transmission takes the level to zero, interrupt state bit 2 (tx empty) is set.
- R9: Reception runs only while control bit 1 is 1. A completed byte appears in receive data bits 7:0. It clears status bit 2 (rx idle) and bit 3 (rx empty), and it sets interrupt state bit 1 when the rx threshold in queue control bits 18:16 is 0.
- R10: Reading the receive data word while control bit 1 is 1 sets status bits 2 and 3. Both bits are 1 after reset.
- R11: A byte that completes while status bit 3 is 0 sets interrupt state bit 3 and replaces the held byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_widx | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line |
| irq_tx_wmark | output | 1 | Transmit watermark interrupt |
| irq_rx_wmark | output | 1 | Receive watermark interrupt |
| irq_tx_empty | output | 1 | Transmit empty interrupt |
| irq_rx_ovf | output | 1 | Receive overflow interrupt |

## Verification
The interrupt gating is swept over all sixteen enable patterns with every state bit forced, which exposes any swapped or stuck line. The queue is filled one byte at a time from empty to one write past full, with a threshold of 4. This separates an off-by-one in the level, the full flag or the watermark compare, and the extra write shows whether an overfull write is dropped. Transmitted bytes are decoded by the bench at two different increments, so a wrong rate or bit order corrupts the bytes. Received frames are sent with the receiver enabled and disabled, read and unread, and with thresholds of 0 and 1, which together separate the status, watermark and overflow paths.

// File: rtl/uart_nco_pkg.sv
package uart_nco_pkg;
   // word indices of the register file
   localparam logic [3:0] REG_ISTATE  = 4'd0;
   localparam logic [3:0] REG_IENABLE = 4'd1;
   localparam logic [3:0] REG_ITEST   = 4'd2;
   localparam logic [3:0] REG_CTRL    = 4'd3;
   localparam logic [3:0] REG_STATUS  = 4'd4;
   localparam logic [3:0] REG_RDATA   = 4'd5;
   localparam logic [3:0] REG_WDATA   = 4'd6;
   localparam logic [3:0] REG_FCTRL   = 4'd7;
   localparam logic [3:0] REG_FSTATUS = 4'd8;
   localparam logic [3:0] REG_OVRD    = 4'd9;
   localparam logic [3:0] REG_VAL     = 4'd10;
   localparam logic [3:0] REG_TMO     = 4'd11;

   // interrupt bit positions
   localparam int unsigned IRQ_TXWM  = 0;
   localparam int unsigned IRQ_RXWM  = 1;
   localparam int unsigned IRQ_TXEMP = 2;
   localparam int unsigned IRQ_RXOVF = 3;
   localparam int unsigned IRQ_N     = 4;

   // control and queue control fields
   localparam int unsigned CTRL_TXEN    = 0;
   localparam int unsigned CTRL_RXEN    = 1;
   localparam int unsigned CTRL_NCO_LSB = 16;
   localparam int unsigned FC_TXFLUSH   = 1;
   localparam int unsigned FC_TXTHR_LSB = 8;
   localparam int unsigned FC_RXTHR_LSB = 16;
   localparam int unsigned FC_RXTHR_W   = 3;

   typedef enum logic [1:0] {
      RXS_IDLE,
      RXS_START,
      RXS_DATA,
      RXS_STOP
   } rx_state_e;
endpackage

// File: rtl/uart_nco_baud.sv
module uart_nco_baud #(
   parameter int unsigned NCO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCO_W-1:0] inc,
   output logic             tick
);
   logic [NCO_W-1:0] acc;
   logic [NCO_W:0]   sum;

   assign sum = {1'b0, acc} + {1'b0, inc};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         tick <= 1'b0;
      end else begin
         acc  <= sum[NCO_W-1:0];
         tick <= sum[NCO_W];
      end
   end
endmodule

// File: rtl/uart_nco_txq.sv
module uart_nco_txq #(
   parameter  int unsigned DEPTH = 32,
   parameter  int unsigned DW    = 8,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned LVL_W = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [DW-1:0]    wdata,
   input  logic             pop,
   input  logic             flush,
   output logic [DW-1:0]    rdata,
   output logic [LVL_W-1:0] level,
   output logic [LVL_W-1:0] level_nx,
   output logic             push_ok
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          full;

   assign full     = (level == LVL_W'(DEPTH));
   assign push_ok  = push & ~full;
   assign rdata    = mem[rd_ptr];
   assign level_nx = flush ? '0 : level + LVL_W'(push_ok) - LVL_W'(pop);

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         level <= level_nx;
         if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop)     rd_ptr <= rd_ptr + 1'b1;
         end
      end
   end

   // R6
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));
   // R6
   flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0));
   // R7
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && level == LVL_W'(DEPTH) && !pop && !flush) |=> (level == LVL_W'(DEPTH)));
endmodule

// File: rtl/uart_nco_txser.sv
module uart_nco_txser #(
   parameter  int unsigned OS_RATE = 16,
   localparam int unsigned CW      = $clog2(OS_RATE)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       start,
   input  logic [7:0] data,
   output logic       busy,
   output logic       line
);
   logic [9:0]    shreg;
   logic [CW-1:0] tcnt;
   logic [3:0]    bcnt;

   assign line = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '1;
         tcnt  <= '0;
         bcnt  <= '0;
         busy  <= 1'b0;
      end else if (start && !busy) begin
         shreg <= {1'b1, data, 1'b0};
         tcnt  <= '0;
         bcnt  <= '0;
         busy  <= 1'b1;
      end else if (busy && tick) begin
         if (tcnt == CW'(OS_RATE - 1)) begin
            tcnt  <= '0;
            shreg <= {1'b1, shreg[9:1]};
            bcnt  <= bcnt + 1'b1;
            if (bcnt == 4'd9) busy <= 1'b0;
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   // R4
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> !line);
endmodule

// File: rtl/uart_nco_rxser.sv
module uart_nco_rxser
   import uart_nco_pkg::*;
#(
   parameter  int unsigned OS_RATE = 16,
   localparam int unsigned CW      = $clog2(OS_RATE)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       rx_in,
   output logic       done,
   output logic [7:0] data
);
   logic          s1, s2;
   rx_state_e     state;
   logic [CW-1:0] cnt;
   logic [2:0]    nbits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b1;
         s2 <= 1'b1;
      end else begin
         s1 <= rx_in;
         s2 <= s1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RXS_IDLE;
         cnt   <= '0;
         nbits <= '0;
         data  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!en) begin
            state <= RXS_IDLE;
         end else if (tick) begin
            case (state)
               RXS_IDLE: begin
                  cnt <= '0;
                  if (!s2) state <= RXS_START;
               end
               RXS_START: begin
                  if (cnt == CW'(OS_RATE / 2 - 1)) begin
                     cnt   <= '0;
                     nbits <= '0;
                     state <= s2 ? RXS_IDLE : RXS_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RXS_DATA: begin
                  if (cnt == CW'(OS_RATE - 1)) begin
                     cnt   <= '0;
                     data  <= {s2, data[7:1]};
                     nbits <= nbits + 1'b1;
                     if (nbits == 3'd7) state <= RXS_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  if (cnt == CW'(OS_RATE - 1)) begin
                     cnt   <= '0;
                     state <= RXS_IDLE;
                     done  <= s2;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_nco.sv
module uart_nco
   import uart_nco_pkg::*;
#(
   parameter int unsigned TXQ_DEPTH = 32,
   parameter int unsigned NCO_W     = 16,
   parameter int unsigned OS_RATE   = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_we,
   input  logic [3:0]  bus_widx,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        ser_tx,
   input  logic        ser_rx,
   output logic        irq_tx_wmark,
   output logic        irq_rx_wmark,
   output logic        irq_tx_empty,
   output logic        irq_rx_ovf
);
   localparam int unsigned THR_W = $clog2(TXQ_DEPTH);
   localparam int unsigned LVL_W = THR_W + 1;

   generate
      if (TXQ_DEPTH < 2 || (TXQ_DEPTH & (TXQ_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("TXQ_DEPTH must be a power of two of at least 2");
      end
      if (CTRL_NCO_LSB + NCO_W > 32) begin : g_bad_nco
         $error("NCO field does not fit the control word");
      end
      if (FC_TXTHR_LSB + THR_W > FC_RXTHR_LSB || LVL_W > 32) begin : g_bad_thr
         $error("transmit threshold field overlaps the receive threshold");
      end
      if (OS_RATE < 4 || (OS_RATE & (OS_RATE - 1)) != 0) begin : g_bad_os
         $error("OS_RATE must be a power of two of at least 4");
      end
   endgenerate

   logic                 wr, rd;
   logic [31:0]          ctrl_q, fctrl_q, ovrd_q, val_q, tmo_q;
   logic [IRQ_N-1:0]     istate_q, ienable_q, hw_set, hw_clr, w1c, tset, irq_vec;
   logic                 rx_idle_q, rx_empty_q;
   logic [7:0]           rx_hold_q;
   logic                 tick, tx_busy, rx_done;
   logic [7:0]           rx_byte, q_head;
   logic                 q_push, q_pop, q_flush, q_push_ok;
   logic [LVL_W-1:0]     q_level, q_level_nx;
   logic [THR_W-1:0]     tx_thr;
   logic [FC_RXTHR_W-1:0] rx_thr;
   logic                 rdata_rd;

   assign wr       = bus_sel & bus_we;
   assign rd       = bus_sel & ~bus_we;
   assign tx_thr   = fctrl_q[FC_TXTHR_LSB +: THR_W];
   assign rx_thr   = fctrl_q[FC_RXTHR_LSB +: FC_RXTHR_W];
   assign q_push   = wr && (bus_widx == REG_WDATA);
   assign q_flush  = wr && (bus_widx == REG_FCTRL) && bus_wdata[FC_TXFLUSH];
   assign q_pop    = ctrl_q[CTRL_TXEN] && !tx_busy && (q_level != '0) && !q_flush;
   assign rdata_rd = rd && (bus_widx == REG_RDATA) && ctrl_q[CTRL_RXEN];
   assign w1c      = (wr && bus_widx == REG_ISTATE) ? bus_wdata[IRQ_N-1:0] : '0;
   assign tset     = (wr && bus_widx == REG_ITEST)  ? bus_wdata[IRQ_N-1:0] : '0;

   uart_nco_baud #(.NCO_W(NCO_W)) u_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (ctrl_q[CTRL_NCO_LSB +: NCO_W]),
      .tick (tick)
   );

   uart_nco_txq #(.DEPTH(TXQ_DEPTH), .DW(8)) u_txq (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (q_push),
      .wdata   (bus_wdata[7:0]),
      .pop     (q_pop),
      .flush   (q_flush),
      .rdata   (q_head),
      .level   (q_level),
      .level_nx(q_level_nx),
      .push_ok (q_push_ok)
   );

   uart_nco_txser #(.OS_RATE(OS_RATE)) u_txser (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .start(q_pop),
      .data (q_head),
      .busy (tx_busy),
      .line (ser_tx)
   );

   uart_nco_rxser #(.OS_RATE(OS_RATE)) u_rxser (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (ctrl_q[CTRL_RXEN]),
      .tick (tick),
      .rx_in(ser_rx),
      .done (rx_done),
      .data (rx_byte)
   );

   // hardware interrupt events
   always_comb begin
      hw_set = '0;
      hw_clr = '0;
      hw_set[IRQ_TXWM]  = q_push_ok && (q_level_nx >= LVL_W'(tx_thr));
      hw_clr[IRQ_TXWM]  = q_pop && ((q_level_nx < LVL_W'(tx_thr)) || (q_level_nx == '0));
      hw_set[IRQ_TXEMP] = q_pop && (q_level_nx == '0);
      hw_set[IRQ_RXWM]  = rx_done && (rx_thr == '0);
      hw_set[IRQ_RXOVF] = rx_done && !rx_empty_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         istate_q   <= '0;
         ienable_q  <= '0;
         ctrl_q     <= '0;
         fctrl_q    <= '0;
         ovrd_q     <= '0;
         val_q      <= '0;
         tmo_q      <= '0;
         rx_hold_q  <= '0;
         rx_idle_q  <= 1'b1;
         rx_empty_q <= 1'b1;
      end else begin
         istate_q <= (((istate_q | hw_set) & ~hw_clr) & ~w1c) | tset;
         if (wr) begin
            case (bus_widx)
               REG_IENABLE: ienable_q <= bus_wdata[IRQ_N-1:0];
               REG_CTRL:    ctrl_q    <= bus_wdata;
               REG_FCTRL:   fctrl_q   <= bus_wdata;
               REG_OVRD:    ovrd_q    <= bus_wdata;
               REG_VAL:     val_q     <= bus_wdata;
               REG_TMO:     tmo_q     <= bus_wdata;
               default: ;
            endcase
         end
         if (rx_done) begin
            rx_hold_q  <= rx_byte;
            rx_idle_q  <= 1'b0;
            rx_empty_q <= 1'b0;
         end else if (rdata_rd) begin
            rx_idle_q  <= 1'b1;
            rx_empty_q <= 1'b1;
         end
      end
   end

   always_comb begin
      case (bus_widx)
         REG_ISTATE:  bus_rdata = {{(32-IRQ_N){1'b0}}, istate_q};
         REG_IENABLE: bus_rdata = {{(32-IRQ_N){1'b0}}, ienable_q};
         REG_CTRL:    bus_rdata = ctrl_q;
         REG_STATUS:  bus_rdata = {28'd0, rx_empty_q, rx_idle_q, (q_level == '0),
                                   (q_level == LVL_W'(TXQ_DEPTH))};
         REG_RDATA:   bus_rdata = {24'd0, rx_hold_q};
         REG_FCTRL:   bus_rdata = fctrl_q;
         REG_FSTATUS: bus_rdata = {{(32-LVL_W){1'b0}}, q_level};
         REG_OVRD:    bus_rdata = ovrd_q;
         REG_VAL:     bus_rdata = val_q;
         REG_TMO:     bus_rdata = tmo_q;
         default:     bus_rdata = '0;
      endcase
   end

   generate
      for (genvar k = 0; k < IRQ_N; k++) begin : g_irq
         assign irq_vec[k] = istate_q[k] & ienable_q[k];
      end
   endgenerate

   assign irq_tx_wmark = irq_vec[IRQ_TXWM];
   assign irq_rx_wmark = irq_vec[IRQ_RXWM];
   assign irq_tx_empty = irq_vec[IRQ_TXEMP];
   assign irq_rx_ovf   = irq_vec[IRQ_RXOVF];

   // R2
   test_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_widx == REG_ITEST) |=>
         ((istate_q & $past(bus_wdata[IRQ_N-1:0])) == $past(bus_wdata[IRQ_N-1:0])));
   // R11
   overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !rx_empty_q && !(wr && bus_widx == REG_ISTATE && bus_wdata[IRQ_RXOVF]))
         |=> istate_q[IRQ_RXOVF]);
endmodule

// File: tb/test_uart_nco.sv
module test_uart_nco;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [3:0]  bus_widx = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        ser_tx, ser_rx = 1'b1;
   logic        irq_tx_wmark, irq_rx_wmark, irq_tx_empty, irq_rx_ovf;

   int checks = 0, errors = 0;
   int bitclk = 32;
   int low_cnt = 0;
   int ngot = 0;
   logic [7:0] got [0:15];
   logic [31:0] v;

   always #10 clk = ~clk;

   uart_nco i_uart_nco (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ser_tx(ser_tx), .ser_rx(ser_rx), .irq_tx_wmark(irq_tx_wmark),
      .irq_rx_wmark(irq_rx_wmark), .irq_tx_empty(irq_tx_empty), .irq_rx_ovf(irq_rx_ovf)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_widx = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_widx = a;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic send_rx(input logic [7:0] b);
      logic [9:0] f;
      f = {1'b1, b, 1'b0};
      for (int i = 0; i < 10; i++) begin
         ser_rx = f[i];
         repeat (bitclk) @(negedge clk);
      end
   endtask

   // line monitor and frame decoder
   initial begin
      logic prev;
      logic [7:0] b;
      prev = 1'b1;
      forever begin
         @(negedge clk);
         if (rst_n && prev && !ser_tx) begin
            repeat (bitclk + bitclk / 2 - 1) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
               b[i] = ser_tx;
               repeat (bitclk) @(negedge clk);
            end
            if (ser_tx && ngot < 16) begin
               got[ngot] = b;
               ngot++;
            end
            prev = 1'b1;
         end else begin
            prev = ser_tx;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (!ser_tx) low_cnt++;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int lc;
      logic [7:0] exp_b [0:4];
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(4'd4, v); chk("R6 R10 reset status", v, 32'hE);
      rd(4'd8, v); chk("R6 reset level", v, 32'h0);
      chk("R1 reset irqs", {28'd0, irq_rx_ovf, irq_tx_empty, irq_rx_wmark, irq_tx_wmark}, 32'h0);

      // R3 stored words
      wr(4'd9, 32'hDEADBEEF);  rd(4'd9, v);  chk("R3 override word", v, 32'hDEADBEEF);
      wr(4'd10, 32'h12345678); rd(4'd10, v); chk("R3 value word", v, 32'h12345678);
      wr(4'd11, 32'h0000A5A5); rd(4'd11, v); chk("R3 timeout word", v, 32'h0000A5A5);
      wr(4'd3, 32'h8000_0020); rd(4'd3, v);  chk("R3 control word", v, 32'h8000_0020);
      rd(4'd8, v); chk("R3 stored fields have no effect", v, 32'h0);

      // R2 test and clear, R1 gating sweep
      wr(4'd2, 32'hF);
      rd(4'd0, v); chk("R2 test sets state", v, 32'hF);
      rd(4'd2, v); chk("R2 test reads zero", v, 32'h0);
      for (int e = 0; e < 16; e++) begin
         wr(4'd1, 32'(e));
         chk("R1 enable sweep", {28'd0, irq_rx_ovf, irq_tx_empty, irq_rx_wmark, irq_tx_wmark}, 32'(e));
      end
      wr(4'd0, 32'h5);
      rd(4'd0, v); chk("R2 write-one clear", v, 32'hA);
      chk("R1 after clear", {28'd0, irq_rx_ovf, irq_tx_empty, irq_rx_wmark, irq_tx_wmark}, 32'hA);
      wr(4'd0, 32'hF);

      // queue fill sweep with threshold 4, transmitter off
      wr(4'd7, 32'(4) << 8);
      lc = low_cnt;
      for (int i = 1; i <= 33; i++) begin
         int exp_l;
         wr(4'd6, 32'(i));
         exp_l = (i > 32) ? 32 : i;
         rd(4'd8, v); chk("R6 R7 level", v, 32'(exp_l));
         rd(4'd0, v); chk("R5 watermark on fill", {31'd0, v[0]}, {31'd0, exp_l >= 4});
      end
      rd(4'd4, v); chk("R6 full flag", {30'd0, v[1:0]}, 32'h1);
      chk("R8 no output while disabled", 32'(low_cnt), 32'(lc));
      wr(4'd7, (32'(4) << 8) | 32'h2);
      rd(4'd8, v); chk("R6 flush level", v, 32'h0);
      rd(4'd4, v); chk("R6 empty flag", {30'd0, v[1:0]}, 32'h2);

      // drain five bytes at 32 clocks per bit
      wr(4'd0, 32'hF);
      ngot = 0;
      for (int k = 0; k < 5; k++) begin
         exp_b[k] = 8'h5A + 8'(k * 37);
         wr(4'd6, {24'd0, exp_b[k]});
      end
      rd(4'd0, v); chk("R5 watermark set at threshold", {31'd0, v[0]}, 32'h1);
      wr(4'd3, 32'h8000_0001);
      repeat (700) @(negedge clk);
      rd(4'd0, v); chk("R5 watermark cleared below threshold", {31'd0, v[0]}, 32'h0);
      repeat (2000) @(negedge clk);
      rd(4'd8, v); chk("R8 drained level", v, 32'h0);
      rd(4'd0, v); chk("R8 tx empty state", {31'd0, v[2]}, 32'h1);
      chk("R4 frame count", 32'(ngot), 32'd5);
      for (int k = 0; k < 5; k++) chk("R4 byte at N=0x8000", {24'd0, got[k]}, {24'd0, exp_b[k]});

      // slower rate
      bitclk = 64;
      wr(4'd3, 32'h4000_0001);
      ngot = 0;
      wr(4'd6, 32'h96);
      repeat (64 * 10 + 100) @(negedge clk);
      chk("R4 frame count at N=0x4000", 32'(ngot), 32'd1);
      chk("R4 byte at N=0x4000", {24'd0, got[0]}, 32'h96);

      // receive path
      bitclk = 32;
      wr(4'd3, 32'h8000_0002);
      wr(4'd7, 32'h0);
      wr(4'd0, 32'hF);
      send_rx(8'hC3);
      repeat (8) @(negedge clk);
      rd(4'd4, v); chk("R9 status after receive", {30'd0, v[3:2]}, 32'h0);
      rd(4'd0, v); chk("R9 rx watermark threshold 0", {31'd0, v[1]}, 32'h1);
      rd(4'd5, v); chk("R9 received byte", v, 32'hC3);
      rd(4'd4, v); chk("R10 status after read", {30'd0, v[3:2]}, 32'h3);

      wr(4'd7, 32'(1) << 16);
      wr(4'd0, 32'hF);
      send_rx(8'h3C);
      repeat (8) @(negedge clk);
      rd(4'd0, v); chk("R9 no rx watermark threshold 1", {31'd0, v[1]}, 32'h0);
      chk("R11 no overflow after read", {31'd0, v[3]}, 32'h0);
      send_rx(8'h81);
      repeat (8) @(negedge clk);
      rd(4'd0, v); chk("R11 overflow state", {31'd0, v[3]}, 32'h1);
      rd(4'd5, v); chk("R11 newer byte kept", v, 32'h81);

      // receiver disabled
      wr(4'd3, 32'h8000_0000);
      send_rx(8'h55);
      repeat (8) @(negedge clk);
      rd(4'd4, v); chk("R9 disabled rx keeps empty", {31'd0, v[3]}, 32'h1);
      rd(4'd5, v); chk("R9 disabled rx keeps data", v, 32'h81);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule